// File: doc/BRIEF.md
# Scaler parameter calculation engine

This block turns a requested layer scaling into the register words a polyphase scaler needs. On a start pulse it captures a mask of the layers that ask for scaling, a source width and height in unsigned 16.16 fixed point, and a destination width and height in whole pixels. It then produces five kinds of result: the per-axis scale factors, the initial-phase and phase-step words, the filter coefficient set for each axis, the packed input and output sizes, and a scale-enable or error verdict. It raises `done` for one cycle when the results are ready.

All six divisions share one restoring 64-by-32 divider and run one after another. The requests it refuses are shrinking, a request from more than one layer, and a zero size that would be used as a divisor. An empty layer mask is a valid request that turns scaling off. A run that passes all checks finishes in about 400 cycles. The results do not change between the `done` pulse and the next accepted start.

The control is one state machine with these states:
- `ST_IDLE` waits for `start`.
- `ST_CHECK` judges the captured request.
- `ST_ISSUE` launches one division.
- `ST_WAIT` waits for the divider and stores its quotient.
- `ST_DONE` raises `done`.

The transitions are:
- idle→check on `start`.
- check→done for an empty mask, a multi-layer mask or a zero divisor.
- check→issue otherwise.
- issue→wait always.
- wait→issue after a quotient is stored when more divisions remain.
- wait→done after the last quotient, or after the vertical factor when either factor shows shrinking.
- done→idle always.

Top module: `scl_param_engine`

## Requirements
- R1: After a run with one mask bit set, a nonzero source and a nonzero destination, `h_factor` equals the low 32 bits of (dst_w << 32) / src_w_fx, and `v_factor` is the same quotient formed from the vertical values.
- R2: If bits 31:16 of either factor are zero, the run ends with `err`=1 and `scale_en`=0. A run with `scale_en`=1 always has both integer parts nonzero.
- R3: A layer mask with more than one bit set ends the run with `err`=1 and `scale_en`=0. The result is reached within 3 cycles of the accepting edge.
- R4: An all-zero mask ends the run with `err`=0 and `scale_en`=0, whatever the sizes are.
- R5: On success, `h_init` = (((src_w_fx >> 16) << 4) / dst_w + 1) / 2 in 32-bit unsigned arithmetic. `v_init` is the same from the vertical values.
- R6: On success, `h_step` = ((src_w_fx >> 16) << 16) / dst_w. `v_step` is the same from the vertical values.
- R7: Each coefficient output is a 3-bit code taken from its axis factor, checked in this order:
  - code 1 if the factor is ≥ 0x10000;
  - code 2 if it is ≥ 0xAAAA;
  - code 3 if it is ≥ 0x8000;
  - code 4 if it is ≥ 0x5D17;
  - code 5 otherwise.
- R8: On success, `in_size` carries the integer source height in bits 28:16 and the integer source width in bits 12:0, with all other bits zero. `out_size` carries the destination sizes in the same layout.
- R9: With one mask bit set, a zero value on any of the four size inputs gives `err`=1 and `scale_en`=0 within 3 cycles, without any division.
- R10: Every accepted start produces exactly one one-cycle `done` pulse. The pulse comes no more than 450 cycles after the accepting edge. After reset `busy`, `done`, `err` and `scale_en` are 0.
- R11: All result outputs keep their values from the `done` pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation; taken only while idle |
| layer_mask | input | LAYERS | One bit per layer asking for scaling |
| src_w_fx | input | 32 | Source width, unsigned 16.16 |
| src_h_fx | input | 32 | Source height, unsigned 16.16 |
| dst_w | input | DIM_W | Destination width in pixels |
| dst_h | input | DIM_W | Destination height in pixels |
| busy | output | 1 | A calculation is in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The last request was refused |
| scale_en | output | 1 | The last request enables scaling |
| h_factor | output | 32 | Horizontal scale factor, 16.16 |
| v_factor | output | 32 | Vertical scale factor, 16.16 |
| h_init | output | 32 | Horizontal initial phase |
| h_step | output | 32 | Horizontal phase step |
| v_init | output | 32 | Vertical initial phase |
| v_step | output | 32 | Vertical phase step |
| h_coef | output | 3 | Horizontal coefficient set code |
| v_coef | output | 3 | Vertical coefficient set code |
| in_size | output | 32 | Packed integer source size |
| out_size | output | 32 | Packed destination size |

## Verification
The assertions rely on three things about the inputs:
- `start` counts only when it is seen while `busy` is low. The checker records the mask and the zero-size condition only at that edge.
- Reset is not pulsed in the middle of a run, so the latency counter always starts from an accepted request.
- Sizes stay below 8192, so the packed fields hold the whole value.

The stimulus keeps to these assumptions. It changes inputs only on falling edges, gives `start` as a single-cycle pulse from idle, and uses sizes of at most 8191. The sweeps cover:
- every 4-bit mask value;
- every pairing of source and destination from 1 to 6 pixels, which reaches all five coefficient codes;
- fractional sources;
- zero sizes;
- a factor that wraps to zero in 32 bits.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;

    localparam int FX_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } scl_state_e;

    // Division order; the vertical factor index is where shrinking is judged.
    localparam logic [2:0] DIV_HFAC  = 3'd0;
    localparam logic [2:0] DIV_VFAC  = 3'd1;
    localparam logic [2:0] DIV_HINIT = 3'd2;
    localparam logic [2:0] DIV_HSTEP = 3'd3;
    localparam logic [2:0] DIV_VINIT = 3'd4;
    localparam logic [2:0] DIV_VSTEP = 3'd5;

    // Reciprocal thresholds in 16.16.
    localparam logic [FX_W-1:0] THR_UNITY = 32'h0001_0000;
    localparam logic [FX_W-1:0] THR_1P5   = 32'h0000_AAAA;
    localparam logic [FX_W-1:0] THR_2P0   = 32'h0000_8000;
    localparam logic [FX_W-1:0] THR_2P75  = 32'h0000_5D17;

    localparam logic [2:0] SET_UP    = 3'd1;
    localparam logic [2:0] SET_DN1P5 = 3'd2;
    localparam logic [2:0] SET_DN2P0 = 3'd3;
    localparam logic [2:0] SET_DN2P75 = 3'd4;
    localparam logic [2:0] SET_DN4P0 = 3'd5;

    function automatic logic [2:0] pick_set(input logic [FX_W-1:0] f);
        if (f >= THR_UNITY)     return SET_UP;
        else if (f >= THR_1P5)  return SET_DN1P5;
        else if (f >= THR_2P0)  return SET_DN2P0;
        else if (f >= THR_2P75) return SET_DN2P75;
        else                    return SET_DN4P0;
    endfunction

endpackage

// File: rtl/scl_div.sv
`timescale 1ns/1ps
module scl_div #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32,
    parameter int Q_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [Q_W-1:0]   quotient
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVS_W:0]   partial;
    logic [DVS_W:0]   diff;

    // The sign of the trial difference decides the quotient bit.
    assign partial  = {rem_q, quo_q[DVD_W-1]};
    assign diff     = partial - {1'b0, dvs_q};
    assign quotient = quo_q[Q_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quo_q <= dividend;
                rem_q <= '0;
                dvs_q <= divisor;
                cnt_q <= CNT_W'(DVD_W);
            end else if (cnt_q != '0) begin
                quo_q <= {quo_q[DVD_W-2:0], ~diff[DVS_W]};
                rem_q <= diff[DVS_W] ? partial[DVS_W-1:0] : diff[DVS_W-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/scl_opnd.sv
`timescale 1ns/1ps
module scl_opnd
    import scl_pkg::*;
#(
    parameter int DIM_W      = 16,
    parameter int PH_BITS    = 4,
    parameter int STEP_SHIFT = 16
) (
    input  logic [2:0]        sel,
    input  logic [FX_W-1:0]   src_w,
    input  logic [FX_W-1:0]   src_h,
    input  logic [DIM_W-1:0]  dst_w,
    input  logic [DIM_W-1:0]  dst_h,
    output logic [2*FX_W-1:0] dividend,
    output logic [FX_W-1:0]   divisor
);
    localparam int FRAC  = FX_W / 2;
    localparam int INT_W = FX_W - FRAC;
    localparam int DVD_W = 2 * FX_W;

    logic [INT_W-1:0] in_w;
    logic [INT_W-1:0] in_h;

    assign in_w = src_w[FX_W-1:FRAC];
    assign in_h = src_h[FX_W-1:FRAC];

    always_comb begin
        dividend = '0;
        divisor  = '0;
        unique case (sel)
            DIV_HFAC: begin
                dividend = DVD_W'(dst_w) << FX_W;
                divisor  = src_w;
            end
            DIV_VFAC: begin
                dividend = DVD_W'(dst_h) << FX_W;
                divisor  = src_h;
            end
            DIV_HINIT: begin
                dividend = DVD_W'(in_w) << PH_BITS;
                divisor  = FX_W'(dst_w);
            end
            DIV_HSTEP: begin
                dividend = DVD_W'(in_w) << STEP_SHIFT;
                divisor  = FX_W'(dst_w);
            end
            DIV_VINIT: begin
                dividend = DVD_W'(in_h) << PH_BITS;
                divisor  = FX_W'(dst_h);
            end
            DIV_VSTEP: begin
                dividend = DVD_W'(in_h) << STEP_SHIFT;
                divisor  = FX_W'(dst_h);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scl_coef_sel.sv
`timescale 1ns/1ps
module scl_coef_sel
    import scl_pkg::*;
(
    input  logic [FX_W-1:0] factor,
    output logic [2:0]      set_id
);
    assign set_id = pick_set(factor);
endmodule

// File: rtl/scl_param_engine.sv
`timescale 1ns/1ps
module scl_param_engine
    import scl_pkg::*;
#(
    parameter int LAYERS     = 4,
    parameter int DIM_W      = 16,
    parameter int SZ_W       = 13,
    parameter int SZ_V_LSB   = 16,
    parameter int PH_BITS    = 4,
    parameter int STEP_SHIFT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LAYERS-1:0] layer_mask,
    input  logic [FX_W-1:0]   src_w_fx,
    input  logic [FX_W-1:0]   src_h_fx,
    input  logic [DIM_W-1:0]  dst_w,
    input  logic [DIM_W-1:0]  dst_h,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              scale_en,
    output logic [FX_W-1:0]   h_factor,
    output logic [FX_W-1:0]   v_factor,
    output logic [FX_W-1:0]   h_init,
    output logic [FX_W-1:0]   h_step,
    output logic [FX_W-1:0]   v_init,
    output logic [FX_W-1:0]   v_step,
    output logic [2:0]        h_coef,
    output logic [2:0]        v_coef,
    output logic [FX_W-1:0]   in_size,
    output logic [FX_W-1:0]   out_size
);
    localparam int DVD_W = 2 * FX_W;
    localparam int FRAC  = FX_W / 2;

    scl_state_e state_q, state_d;

    logic [LAYERS-1:0] mask_q;
    logic [FX_W-1:0]   src_w_q, src_h_q;
    logic [DIM_W-1:0]  dst_w_q, dst_h_q;
    logic [2:0]        idx_q;
    logic              err_q, scale_q;
    logic [FX_W-1:0]   res_q [6];
    logic [FX_W-1:0]   in_size_q, out_size_q;

    logic              div_start, div_done;
    logic [DVD_W-1:0]  div_dvd;
    logic [FX_W-1:0]   div_dvs, div_quo;
    logic              mask_empty, mask_multi, size_zero, shrink, last_div;

    function automatic logic [FX_W-1:0] pack_size(input logic [DIM_W-1:0] hz,
                                                  input logic [DIM_W-1:0] vt);
        logic [FX_W-1:0] r;
        r = '0;
        r[SZ_W-1:0]            = hz[SZ_W-1:0];
        r[SZ_V_LSB +: SZ_W]    = vt[SZ_W-1:0];
        return r;
    endfunction

    assign mask_empty = (mask_q == '0);
    assign mask_multi = |(mask_q & (mask_q - 1'b1));
    assign size_zero  = (src_w_q == '0) || (src_h_q == '0) ||
                        (dst_w_q == '0) || (dst_h_q == '0);
    assign shrink     = (res_q[DIV_HFAC][FX_W-1:FRAC] == '0) ||
                        (div_quo[FX_W-1:FRAC] == '0);
    assign last_div   = (idx_q == DIV_VSTEP);

    scl_opnd #(
        .DIM_W(DIM_W), .PH_BITS(PH_BITS), .STEP_SHIFT(STEP_SHIFT)
    ) u_opnd (
        .sel(idx_q), .src_w(src_w_q), .src_h(src_h_q),
        .dst_w(dst_w_q), .dst_h(dst_h_q),
        .dividend(div_dvd), .divisor(div_dvs)
    );

    scl_div #(.DVD_W(DVD_W), .DVS_W(FX_W), .Q_W(FX_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(div_dvd), .divisor(div_dvs),
        .done(div_done), .quotient(div_quo)
    );

    logic [FX_W-1:0] axis_fac [2];
    logic [2:0]      axis_set [2];
    assign axis_fac[0] = res_q[DIV_HFAC];
    assign axis_fac[1] = res_q[DIV_VFAC];

    generate
        for (genvar g = 0; g < 2; g++) begin : g_axis
            scl_coef_sel u_sel (.factor(axis_fac[g]), .set_id(axis_set[g]));
        end
    endgenerate

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: state_d = (mask_empty || mask_multi || size_zero) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (div_done) begin
                          if ((idx_q == DIV_VFAC && shrink) || last_div) state_d = ST_DONE;
                          else                                          state_d = ST_ISSUE;
                      end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Control outputs decoded from state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        div_start = (state_q == ST_ISSUE);
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '0;
            src_w_q    <= '0;
            src_h_q    <= '0;
            dst_w_q    <= '0;
            dst_h_q    <= '0;
            idx_q      <= DIV_HFAC;
            err_q      <= 1'b0;
            scale_q    <= 1'b0;
            in_size_q  <= '0;
            out_size_q <= '0;
            for (int i = 0; i < 6; i++) res_q[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    mask_q  <= layer_mask;
                    src_w_q <= src_w_fx;
                    src_h_q <= src_h_fx;
                    dst_w_q <= dst_w;
                    dst_h_q <= dst_h;
                    err_q   <= 1'b0;
                    scale_q <= 1'b0;
                end
                ST_CHECK: begin
                    idx_q <= DIV_HFAC;
                    if (!mask_empty) begin
                        if (mask_multi || size_zero) begin
                            err_q <= 1'b1;
                        end else begin
                            in_size_q  <= pack_size(src_w_q[FX_W-1:FRAC], src_h_q[FX_W-1:FRAC]);
                            out_size_q <= pack_size(dst_w_q, dst_h_q);
                        end
                    end
                end
                ST_WAIT: if (div_done) begin
                    case (idx_q)
                        DIV_HINIT, DIV_VINIT: res_q[idx_q] <= (div_quo + FX_W'(1)) >> 1;
                        default:              res_q[idx_q] <= div_quo;
                    endcase
                    if (idx_q == DIV_VFAC && shrink) err_q   <= 1'b1;
                    else if (last_div)               scale_q <= 1'b1;
                    idx_q <= idx_q + 3'd1;
                end
                default: ;
            endcase
        end
    end

    assign err      = err_q;
    assign scale_en = scale_q;
    assign h_factor = res_q[DIV_HFAC];
    assign v_factor = res_q[DIV_VFAC];
    assign h_init   = res_q[DIV_HINIT];
    assign h_step   = res_q[DIV_HSTEP];
    assign v_init   = res_q[DIV_VINIT];
    assign v_step   = res_q[DIV_VSTEP];
    assign h_coef   = axis_set[0];
    assign v_coef   = axis_set[1];
    assign in_size  = in_size_q;
    assign out_size = out_size_q;

endmodule

// File: rtl/scl_param_chk.sv
`timescale 1ns/1ps
module scl_param_chk #(
    parameter int LAYERS  = 4,
    parameter int DIM_W   = 16,
    parameter int LAT_MAX = 450
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              scale_en,
    input logic [LAYERS-1:0] layer_mask,
    input logic [31:0]       src_w_fx,
    input logic [31:0]       src_h_fx,
    input logic [DIM_W-1:0]  dst_w,
    input logic [DIM_W-1:0]  dst_h,
    input logic [31:0]       h_factor,
    input logic [31:0]       v_factor,
    input logic [31:0]       h_init,
    input logic [31:0]       h_step,
    input logic [31:0]       v_init,
    input logic [31:0]       v_step,
    input logic [2:0]        h_coef,
    input logic [2:0]        v_coef,
    input logic [31:0]       in_size,
    input logic [31:0]       out_size
);
    logic [LAYERS-1:0] mask_seen;
    logic              zero_seen;
    logic [9:0]        lat_q;
    logic              seen_multi;

    assign seen_multi = |(mask_seen & (mask_seen - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_seen <= '0;
            zero_seen <= 1'b0;
            lat_q     <= '0;
        end else if (start && !busy) begin
            mask_seen <= layer_mask;
            zero_seen <= (src_w_fx == 0) || (src_h_fx == 0) || (dst_w == 0) || (dst_h == 0);
            lat_q     <= 10'd1;
        end else if (busy && lat_q != '1) begin
            lat_q <= lat_q + 10'd1;
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat_q <= 10'(LAT_MAX)));

    p_multi_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seen_multi) |-> (err && !scale_en && lat_q <= 10'd3));

    p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mask_seen == '0) |-> (!err && !scale_en));

    p_zero_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_seen && mask_seen != '0 && !seen_multi) |-> (err && !scale_en && lat_q <= 10'd3));

    p_no_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && scale_en) |-> (h_factor[31:16] != 16'd0 && v_factor[31:16] != 16'd0 && !err));

    p_upscale_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && scale_en) |-> (h_coef == 3'd1 && v_coef == 3'd1));

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({h_factor, v_factor, h_init, h_step, v_init, v_step,
                                       h_coef, v_coef, in_size, out_size, err, scale_en}));

    p_hold_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable({h_factor, v_factor, h_init, h_step, v_init, v_step,
                          h_coef, v_coef, in_size, out_size, err, scale_en}));

endmodule

bind scl_param_engine scl_param_chk #(.LAYERS(LAYERS), .DIM_W(DIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .scale_en(scale_en), .layer_mask(layer_mask),
    .src_w_fx(src_w_fx), .src_h_fx(src_h_fx), .dst_w(dst_w), .dst_h(dst_h),
    .h_factor(h_factor), .v_factor(v_factor), .h_init(h_init), .h_step(h_step),
    .v_init(v_init), .v_step(v_step), .h_coef(h_coef), .v_coef(v_coef),
    .in_size(in_size), .out_size(out_size)
);

// File: tb/scl_param_engine_test.sv
`timescale 1ns/1ps
module scl_param_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mask = '0;
    logic [31:0] sw = '0, sh = '0;
    logic [15:0] dw = '0, dh = '0;
    logic        busy, done, err, scale_en;
    logic [31:0] h_factor, v_factor, h_init, h_step, v_init, v_step, in_size, out_size;
    logic [2:0]  h_coef, v_coef;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    scl_param_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .layer_mask(mask),
        .src_w_fx(sw), .src_h_fx(sh), .dst_w(dw), .dst_h(dh),
        .busy(busy), .done(done), .err(err), .scale_en(scale_en),
        .h_factor(h_factor), .v_factor(v_factor), .h_init(h_init), .h_step(h_step),
        .v_init(v_init), .v_step(v_step), .h_coef(h_coef), .v_coef(v_coef),
        .in_size(in_size), .out_size(out_size)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_set(input logic [31:0] f);
        if (f >= 32'h10000) return 3'd1;
        if (f >= 32'hAAAA)  return 3'd2;
        if (f >= 32'h8000)  return 3'd3;
        if (f >= 32'h5D17)  return 3'd4;
        return 3'd5;
    endfunction

    task automatic run(input logic [3:0] m, input logic [31:0] s_w, input logic [31:0] s_h,
                       input logic [15:0] d_w, input logic [15:0] d_h);
        logic [63:0]  hf64, vf64;
        logic [31:0]  hf, vf, iw, ih;
        logic [263:0] snap;
        int lat;
        bit multi, zdiv;
        @(negedge clk);
        mask = m; sw = s_w; sh = s_h; dw = d_w; dh = d_h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk("R10 done pulse seen", done, 1);
        chk("R10 latency within 450", lat <= 450, 1);
        multi = (m & (m - 4'd1)) != 0;
        zdiv  = (s_w == 0) || (s_h == 0) || (d_w == 0) || (d_h == 0);
        if (m == 0) begin
            chk("R4 empty mask err", err, 0);
            chk("R4 empty mask scale_en", scale_en, 0);
        end else if (multi) begin
            chk("R3 multi mask err", err, 1);
            chk("R3 multi mask scale_en", scale_en, 0);
            chk("R3 multi mask quick", lat <= 3, 1);
        end else if (zdiv) begin
            chk("R9 zero size err", err, 1);
            chk("R9 zero size scale_en", scale_en, 0);
            chk("R9 zero size quick", lat <= 3, 1);
        end else begin
            hf64 = (64'(d_w) << 32) / 64'(s_w);
            vf64 = (64'(d_h) << 32) / 64'(s_h);
            hf = hf64[31:0];
            vf = vf64[31:0];
            chk("R1 h_factor", h_factor, hf);
            chk("R1 v_factor", v_factor, vf);
            chk("R7 h_coef", 32'(h_coef), 32'(ref_set(hf)));
            chk("R7 v_coef", 32'(v_coef), 32'(ref_set(vf)));
            if (hf[31:16] == 0 || vf[31:16] == 0) begin
                chk("R2 shrink err", err, 1);
                chk("R2 shrink scale_en", scale_en, 0);
            end else begin
                iw = s_w >> 16;
                ih = s_h >> 16;
                chk("R2 upscale err", err, 0);
                chk("R2 upscale scale_en", scale_en, 1);
                chk("R5 h_init", h_init, ((iw << 4) / 32'(d_w) + 1) / 2);
                chk("R5 v_init", v_init, ((ih << 4) / 32'(d_h) + 1) / 2);
                chk("R6 h_step", h_step, (iw << 16) / 32'(d_w));
                chk("R6 v_step", v_step, (ih << 16) / 32'(d_h));
                chk("R8 in_size", in_size, {3'b0, ih[12:0], 3'b0, iw[12:0]});
                chk("R8 out_size", out_size, {3'b0, d_h[12:0], 3'b0, d_w[12:0]});
            end
        end
        snap = {h_factor, v_factor, h_init, h_step, v_init, v_step, in_size, out_size,
                h_coef, v_coef, err, scale_en};
        @(negedge clk);
        chk("R10 done is one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk("R11 outputs held", snap == {h_factor, v_factor, h_init, h_step, v_init, v_step,
                                         in_size, out_size, h_coef, v_coef, err, scale_en}, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R10 reset err", err, 0);
        chk("R10 reset scale_en", scale_en, 0);
        rst_n = 1'b1;
        // Every mask value with a fixed upscale request.
        for (int m = 0; m < 16; m++) run(4'(m), 32'h20000, 32'h30000, 16'd4, 16'd6);
        // Integer source and destination sweep: reaches all coefficient codes.
        for (int s = 1; s <= 6; s++)
            for (int d = 1; d <= 6; d++)
                run(4'b0100, 32'(s) << 16, 32'(7 - s) << 16, 16'(d), 16'(7 - d));
        // Fractional sources.
        run(4'b0001, 32'h18000, 32'h28000, 16'd3, 16'd5);
        run(4'b0001, 32'h08000, 32'h10000, 16'd3, 16'd1);
        // Zero sizes.
        run(4'b0010, 32'h0, 32'h10000, 16'd2, 16'd2);
        run(4'b0010, 32'h10000, 32'h0, 16'd2, 16'd2);
        run(4'b0010, 32'h10000, 32'h10000, 16'd0, 16'd2);
        run(4'b0010, 32'h10000, 32'h10000, 16'd2, 16'd0);
        run(4'b0000, 32'h0, 32'h0, 16'd0, 16'd0);
        // Large sizes and a factor that wraps to zero.
        run(4'b1000, 32'd640 << 16, 32'd480 << 16, 16'd1920, 16'd1080);
        run(4'b0010, 32'h10000, 32'h10000, 16'd8191, 16'd8191);
        run(4'b0001, 32'h100, 32'h10000, 16'd256, 16'd2);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule